// File: doc/BRIEF.md
# Half-Flash Converter Control Sequencer

This block is the digital sequencer of a multiplexed 8-bit two-step (half-flash) converter. A host starts a conversion by pulling chip select and read low together. On that edge the sequencer captures the channel address and drives it to the analog multiplexer. It then counts a tracking window of clock-enable ticks. At the end of that window it reduces the coarse comparator bank's thermometer code to a 4-bit nibble, which also feeds the residue DAC. It then counts a fine window, after which it reduces the fine bank's thermometer code. The two nibbles form the 8-bit result, with the coarse nibble on top, and completion is signalled on an active-low interrupt.

Two read styles are supported, chosen by a static mode input. In hold-read mode the host keeps read low through the whole conversion. The data bus stays disabled until the result exists, and the ready pull-down stretches the host's bus cycle until then. In pipelined mode a short read returns the previous result at once while the new conversion runs in the background, and a later read fetches it. A start edge that arrives during a conversion is dropped and recorded in a sticky violation flag.

Top module: `hflash_seq`

## Requirements
- R1: After reset, intN is 1, rdyPullDn is 0, dataOe is 0, dataOut is 0, chanSel is 0, coarseCode is 0 and startViolation is 0.
- R2: A conversion starts on a clock where the previous sampled value of (csN OR rdN) was 1 and the current one is 0 while no conversion runs. chanSel takes the value of chanAddr after that clock (0 selects input 1, n selects input n+1) and does not change at any other time.
- R3: The coarse latch happens on the TRACK_TICKS-th clock with tickEn high after the start. coarseCode then becomes the number of ones in coarseTherm.
- R4: The fine latch happens on the FINE_TICKS-th tickEn clock after the coarse latch. dataOut then becomes {coarseCode, number of ones in fineTherm}, bits 7:4 coarse and bits 3:0 fine, and intN goes to 0 on that clock.
- R5: intN returns to 1 one clock after a rising edge of csN or of rdN, unless the fine latch happens on that same clock.
- R6: rdyPullDn goes to 1 one clock after a falling edge of csN. It goes to 0 after a rising edge of csN, and in hold-read mode (pipeMode=0) also after the fine latch.
- R7: In hold-read mode, dataOe is 1 only while csN and rdN are both low, were both low on the previous clock, and no conversion runs.
- R8: In pipelined mode (pipeMode=1), dataOe is 1 whenever csN and rdN are both low. During that read dataOut shows the previous result.
- R9: A start edge during a conversion leaves chanSel and the timing of the conversion unchanged, and sets startViolation. startViolation stays 1 until reset.
- R10: Clocks with tickEn low do not advance either window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timing tick enable; one tick is one unit of both windows |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read |
| pipeMode | input | 1 | 0 = hold-read, 1 = pipelined read |
| chanAddr | input | ADDR_W | Channel address captured at the start edge |
| coarseTherm | input | THERM_W | Thermometer code from the coarse comparator bank |
| fineTherm | input | THERM_W | Thermometer code from the fine comparator bank |
| chanSel | output | ADDR_W | Latched multiplexer channel |
| coarseCode | output | NIB_W | Coarse nibble to the residue DAC |
| dataOut | output | 2*NIB_W | Conversion result |
| dataOe | output | 1 | Output enable for the tri-state data bus |
| intN | output | 1 | Active-low end-of-conversion interrupt |
| rdyPullDn | output | 1 | 1 turns on the open-drain ready pull-down |
| startViolation | output | 1 | Sticky flag for a start edge that arrived during a conversion |

## Verification
A wrong phase or tick count inside the sequencer shows up as an interrupt falling or a result changing on the wrong clock. The per-clock comparison against the behavioural model catches this in the very cycle of the first divergence, not only at the end of a read. A wrong edge memory shows up within one clock as a misplaced ready pull-down or data enable. A start that is wrongly accepted during a conversion shows up at once on chanSel and then as an early interrupt. The tick rate is varied so that counting on plain clocks cannot hide behind a tick that is high every cycle.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRACK = 2'd1,
    PH_FINE  = 2'd2
  } hfsPhase_t;

  typedef struct packed {
    logic latchChan;
    logic latchCoarse;
    logic latchFine;
  } hfsStrb_t;
endpackage

// File: rtl/hfs_ctrl.sv
module hfs_ctrl
  import hfs_pkg::*;
#(
  parameter int TRACK_TICKS = 10,
  parameter int FINE_TICKS  = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     csN,
  input  logic     rdN,
  input  logic     pipeMode,
  output hfsStrb_t strb,
  output logic     dataOe,
  output logic     intN,
  output logic     rdyPullDn,
  output logic     startViolation
);
  localparam int MAXT  = (TRACK_TICKS > FINE_TICKS) ? TRACK_TICKS : FINE_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] TRACK_LAST = CNT_W'(TRACK_TICKS - 1);
  localparam logic [CNT_W-1:0] FINE_LAST  = CNT_W'(FINE_TICKS - 1);

  hfsPhase_t phase;
  logic [CNT_W-1:0] tickCnt;
  logic csQ, rdQ;
  logic selN, selQ, startEdge, csFall, csRise, rdRise, busy;
  logic trackEnd, fineEnd;

  always_comb begin
    selN      = csN | rdN;
    selQ      = csQ | rdQ;
    startEdge = selQ & ~selN;
    csFall    = csQ & ~csN;
    csRise    = ~csQ & csN;
    rdRise    = ~rdQ & rdN;
    busy      = (phase != PH_IDLE);
    trackEnd  = (phase == PH_TRACK) && tickEn && (tickCnt == TRACK_LAST);
    fineEnd   = (phase == PH_FINE) && tickEn && (tickCnt == FINE_LAST);
    strb.latchChan   = startEdge & ~busy;
    strb.latchCoarse = trackEnd;
    strb.latchFine   = fineEnd;
    dataOe = pipeMode ? ~selN : (~selN & ~selQ & ~busy);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ            <= 1'b1;
      rdQ            <= 1'b1;
      phase          <= PH_IDLE;
      tickCnt        <= '0;
      intN           <= 1'b1;
      rdyPullDn      <= 1'b0;
      startViolation <= 1'b0;
    end else begin
      csQ <= csN;
      rdQ <= rdN;
      if (strb.latchChan) begin
        phase   <= PH_TRACK;
        tickCnt <= '0;
      end else if (busy && tickEn) begin
        if (trackEnd) begin
          phase   <= PH_FINE;
          tickCnt <= '0;
        end else if (fineEnd) begin
          phase   <= PH_IDLE;
          tickCnt <= '0;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
      if (startEdge && busy) startViolation <= 1'b1;
      if (fineEnd) intN <= 1'b0;
      else if (csRise || rdRise) intN <= 1'b1;
      if (csFall) rdyPullDn <= 1'b1;
      else if (csRise || (fineEnd && !pipeMode)) rdyPullDn <= 1'b0;
    end
  end
endmodule

// File: rtl/hfs_dpath.sv
module hfs_dpath
  import hfs_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int THERM_W = 15,
  parameter int NIB_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  hfsStrb_t           strb,
  input  logic [ADDR_W-1:0]  chanAddr,
  input  logic [THERM_W-1:0] coarseTherm,
  input  logic [THERM_W-1:0] fineTherm,
  output logic [ADDR_W-1:0]  chanSel,
  output logic [NIB_W-1:0]   coarseCode,
  output logic [2*NIB_W-1:0] result
);
  function automatic logic [NIB_W-1:0] onesCount(input logic [THERM_W-1:0] v);
    logic [NIB_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < THERM_W; i++) acc = acc + NIB_W'(v[i]);
    return acc;
  endfunction

  logic [NIB_W-1:0] coarseBin, fineBin;
  always_comb begin
    coarseBin = onesCount(coarseTherm);
    fineBin   = onesCount(fineTherm);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanSel    <= '0;
      coarseCode <= '0;
      result     <= '0;
    end else begin
      if (strb.latchChan)   chanSel    <= chanAddr;
      if (strb.latchCoarse) coarseCode <= coarseBin;
      if (strb.latchFine)   result     <= {coarseCode, fineBin};
    end
  end
endmodule

// File: rtl/hflash_seq.sv
module hflash_seq
  import hfs_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int THERM_W     = 15,
  parameter int TRACK_TICKS = 10,
  parameter int FINE_TICKS  = 6,
  localparam int NIB_W      = $clog2(THERM_W + 1),
  localparam int RES_W      = 2 * NIB_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               csN,
  input  logic               rdN,
  input  logic               pipeMode,
  input  logic [ADDR_W-1:0]  chanAddr,
  input  logic [THERM_W-1:0] coarseTherm,
  input  logic [THERM_W-1:0] fineTherm,
  output logic [ADDR_W-1:0]  chanSel,
  output logic [NIB_W-1:0]   coarseCode,
  output logic [RES_W-1:0]   dataOut,
  output logic               dataOe,
  output logic               intN,
  output logic               rdyPullDn,
  output logic               startViolation
);
  hfsStrb_t strb;

  hfs_ctrl #(.TRACK_TICKS(TRACK_TICKS), .FINE_TICKS(FINE_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .csN(csN), .rdN(rdN),
    .pipeMode(pipeMode), .strb(strb), .dataOe(dataOe), .intN(intN),
    .rdyPullDn(rdyPullDn), .startViolation(startViolation)
  );

  hfs_dpath #(.ADDR_W(ADDR_W), .THERM_W(THERM_W), .NIB_W(NIB_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .chanAddr(chanAddr),
    .coarseTherm(coarseTherm), .fineTherm(fineTherm), .chanSel(chanSel),
    .coarseCode(coarseCode), .result(dataOut)
  );
endmodule

// File: rtl/hfs_checker.sv
module hfs_checker
  import hfs_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdN,
  input logic              pipeMode,
  input hfsStrb_t          strb,
  input logic [ADDR_W-1:0] chanSel,
  input logic              dataOe,
  input logic              intN,
  input logic              rdyPullDn,
  input logic              startViolation
);
  p_chan_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchChan |=> $stable(chanSel));

  p_strb_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.latchChan, strb.latchCoarse, strb.latchFine}));

  p_int_on_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchFine |=> !intN);

  p_int_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (($rose(csN) || $rose(rdN)) && !strb.latchFine) |=> intN);

  p_rdy_pull_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |=> rdyPullDn);

  p_hold_oe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && strb.latchCoarse) |-> !dataOe);

  p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    startViolation |=> startViolation);
endmodule

bind hflash_seq hfs_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .pipeMode(pipeMode),
  .strb(strb), .chanSel(chanSel), .dataOe(dataOe), .intN(intN),
  .rdyPullDn(rdyPullDn), .startViolation(startViolation)
);

// File: tb/test_hflash_seq.sv
`timescale 1ns/1ps
module test_hflash_seq;
  localparam int TRK = 10;
  localparam int FIN = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic csN = 1'b1;
  logic rdN = 1'b1;
  logic pipeMode = 1'b0;
  logic [2:0] chanAddr = 3'd0;
  logic [14:0] coarseTherm = '0;
  logic [14:0] fineTherm = '0;
  logic [2:0] chanSel;
  logic [3:0] coarseCode;
  logic [7:0] dataOut;
  logic dataOe, intN, rdyPullDn, startViolation;

  int nCmp = 0;
  int nBad = 0;
  int tickDiv = 1;
  int cycles = 0;

  hflash_seq i_hflash_seq (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .csN(csN), .rdN(rdN),
    .pipeMode(pipeMode), .chanAddr(chanAddr), .coarseTherm(coarseTherm),
    .fineTherm(fineTherm), .chanSel(chanSel), .coarseCode(coarseCode),
    .dataOut(dataOut), .dataOe(dataOe), .intN(intN), .rdyPullDn(rdyPullDn),
    .startViolation(startViolation)
  );

  always #5 clk = ~clk;

  function automatic int ones(input logic [14:0] v);
    int n = 0;
    for (int i = 0; i < 15; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic logic [14:0] therm(input int n);
    logic [31:0] t = (32'h1 << n) - 32'h1;
    return t[14:0];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference model
  int mPhase = 0, mCnt = 0, mChan = 0, mCoarse = 0, mResult = 0;
  bit mInt = 1, mRdy = 0, mViol = 0, pSel = 1, pCs = 1, pRd = 1;

  always @(posedge clk) begin
    bit sel, done, startE, busyOld;
    sel = csN | rdN;
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mChan = 0; mCoarse = 0; mResult = 0;
      mInt = 1; mRdy = 0; mViol = 0; pSel = 1; pCs = 1; pRd = 1;
    end else begin
      busyOld = (mPhase != 0);
      startE = pSel && !sel;
      done = 0;
      if (mPhase == 1 && tickEn) begin      // R10: only tick clocks count
        if (mCnt == TRK - 1) begin mCoarse = ones(coarseTherm); mPhase = 2; mCnt = 0; end
        else mCnt++;
      end else if (mPhase == 2 && tickEn) begin
        if (mCnt == FIN - 1) begin
          mResult = mCoarse * 16 + ones(fineTherm); mPhase = 0; mCnt = 0; done = 1;
        end else mCnt++;
      end
      if (startE) begin
        if (busyOld) mViol = 1;
        else begin mChan = chanAddr; mPhase = 1; mCnt = 0; end
      end
      if (done) mInt = 0;
      else if ((!pCs && csN) || (!pRd && rdN)) mInt = 1;
      if (pCs && !csN) mRdy = 1;
      else if ((!pCs && csN) || (done && !pipeMode)) mRdy = 0;
      pSel = sel; pCs = csN; pRd = rdN;
    end
    #2;
    if (rstN) begin
      bit expOe;
      expOe = pipeMode ? !(csN | rdN) : (!(csN | rdN) && !pSel && mPhase == 0);
      chk("R2 chanSel", chanSel, mChan);
      chk("R3 coarseCode", coarseCode, mCoarse);
      chk("R4 dataOut", dataOut, mResult);
      chk("R5 intN", intN, mInt);
      chk("R6 rdyPullDn", rdyPullDn, mRdy);
      chk(pipeMode ? "R8 dataOe" : "R7 dataOe", dataOe, expOe);
      chk("R9 startViolation", startViolation, mViol);
    end
  end

  // tick generator, rate set by tickDiv (R10)
  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      t++;
      tickEn = (t % tickDiv) == 0;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nBad++;
        $display("FAIL R4 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
        $finish;
      end
    end
  end

  task automatic holdRead(input int addr, input int c, input int f, input int exp);
    @(negedge clk);
    coarseTherm = therm(c); fineTherm = therm(f);
    chanAddr = 3'(addr); csN = 0; rdN = 0;
    for (int i = 0; i < 500 && intN; i++) @(negedge clk);
    @(negedge clk);
    chk("R4 hold result", dataOut, exp);
    chk("R7 hold data enabled after end", dataOe, 1);
    chk("R2 latched channel", chanSel, addr);
    rdN = 1;
    @(negedge clk);
    chk("R5 int released by read rise", intN, 1);
    csN = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pipeRead(input int addr, input int expOld);
    @(negedge clk);
    chanAddr = 3'(addr); csN = 0; rdN = 0;
    @(negedge clk);
    chk("R8 pipelined enable", dataOe, 1);
    chk("R8 previous result", dataOut, expOld);
    @(negedge clk);
    csN = 1; rdN = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 intN", intN, 1);
    chk("R1 rdy", rdyPullDn, 0);
    chk("R1 dataOe", dataOe, 0);
    chk("R1 dataOut", dataOut, 0);
    chk("R1 chanSel", chanSel, 0);
    chk("R1 coarse", coarseCode, 0);
    chk("R1 violation", startViolation, 0);

    holdRead(5, 10, 5, 8'hA5);
    holdRead(0, 15, 0, 8'hF0);
    tickDiv = 3;
    holdRead(7, 0, 15, 8'h0F);

    // address moves with no start edge; chip select alone pulls ready
    @(negedge clk); chanAddr = 3'd3;
    @(negedge clk); csN = 0;
    repeat (2) @(negedge clk);
    chk("R6 ready pulled by cs alone", rdyPullDn, 1);
    chk("R2 channel unchanged", chanSel, 7);
    rdN = 0;                               // combined edge starts here
    repeat (3) @(negedge clk);
    chk("R2 start via read under cs", chanSel, 3);
    for (int i = 0; i < 500 && intN; i++) @(negedge clk);
    rdN = 1; csN = 1;
    repeat (4) @(negedge clk);

    pipeMode = 1; tickDiv = 2;
    coarseTherm = therm(3); fineTherm = therm(7);
    pipeRead(2, mResult);
    repeat (60) @(negedge clk);
    pipeRead(6, 8'h37);
    repeat (5) @(negedge clk);
    pipeRead(1, 8'h37);                    // R9: during conversion, ignored
    chk("R9 channel kept", chanSel, 6);
    chk("R9 violation flag", startViolation, 1);
    repeat (60) @(negedge clk);
    chk("R9 flag sticky", startViolation, 1);
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule